// File: doc/BRIEF.md
# Timed Multi-Channel Sample Latch with Byte-Stream FIFO Writer

The block paces a measurement system. A reloadable divider counts system clocks and issues a one-cycle sample pulse each time it reaches a programmed limit. The pulse is generated internally, so it does not wait for any host command. On every pulse the block captures three converter words and four axis position counts in the same clock edge, which gives one record whose values all belong to one instant. The captured record then leaves the block one byte per cycle toward an external 9-bit-wide FIFO. The ninth bit marks the first byte of each record.

The block also keeps its own count of how full the external FIFO is. That count goes up on each write it issues and down on each host read that it observes. When the count reaches a programmable threshold, the block raises an interrupt request. The host may drain the FIFO while new records keep arriving. Records that cannot be stored are refused whole and counted. Pulses that arrive while a record is still being sent out are also counted and skipped.

Top module: `acq_sync_latch`

## Requirements
- R1: With `enable` high, `sample_strobe` is a one-cycle pulse. The first pulse comes `reload`+1 cycles after `enable` rises, and later pulses come every `reload`+1 cycles. If `reload` is set below the current count, the next cycle produces a pulse.
- R2: All seven channels are sampled on the clock edge that follows a `sample_strobe` pulse. The emitted bytes carry exactly those values, even if the inputs change later.
- R3: An accepted record is 22 consecutive write cycles (`fifo_wr` high), starting two cycles after the pulse. The byte order is converter channels 0..2, then position channels 0..3, each most-significant byte first. `fifo_din[8]` is 1 only on the first byte.
- R4: A pulse that arrives while a record is being sent is skipped, and `overrun_count` increments one cycle later.
- R5: If `fifo_full` is high when a pulse is handled, the record is refused with no write at all, and `drop_count` increments.
- R6: A record is also refused, and counted in `drop_count`, when fewer than 22 free places remain. Occupancy for this test includes the write issued in the same cycle.
- R7: `fill_level` rises by one the cycle after each write and falls by one the cycle after each host read. It is unchanged when both happen together.
- R8: A host read while `fill_level` is 0 has no effect, and the level stays 0.
- R9: `irq` is high exactly one cycle after `fill_level` >= `threshold`. It stays high until the level falls below the threshold.
- R10: `drop_count` and `overrun_count` saturate at their all-ones value.
- R11: Reset clears all outputs and counters. While `enable` is low, no pulse and no new record is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the sample divider |
| reload | input | CNT_W | Divider limit; period is reload+1 cycles |
| threshold | input | FILL_W | Fill level that raises the interrupt |
| adc_flat | input | ADC_CH*ADC_W | Converter words, channel k at bits [k*ADC_W +: ADC_W] |
| pos_flat | input | POS_CH*POS_W | Position counts, channel k at bits [k*POS_W +: POS_W] |
| fifo_full | input | 1 | Full flag from the external FIFO |
| fifo_rd | input | 1 | Host read strobe on the external FIFO |
| sample_strobe | output | 1 | One-cycle sample pulse |
| fifo_wr | output | 1 | External FIFO write enable |
| fifo_din | output | 9 | Bit 8 = record start, bits 7:0 = data byte |
| fill_level | output | FILL_W | Tracked FIFO occupancy |
| irq | output | 1 | Fill-threshold interrupt request |
| drop_count | output | CNT_OUT_W | Refused records, saturating |
| overrun_count | output | CNT_OUT_W | Skipped pulses, saturating |

## Verification
Each result has its own latency:
- a pulse appears `reload`+1 edges after its predecessor;
- the first byte of the captured record is on `fifo_din` two edges after the pulse;
- `drop_count` and `overrun_count` move one edge after the pulse;
- `fill_level` moves one edge after the write or read it reflects, and `irq` follows one edge after that.

A behavioural reference model advances on the same edges with these latencies and is compared with every output at each falling edge. Directed checks at the ends of phases pin the absolute values of level, counters and interrupt.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = BYTE_W + 1;

  typedef logic [WORD_W-1:0] fifo_word_t;

  function automatic int bytes_of(input int bits);
    return (bits + BYTE_W - 1) / BYTE_W;
  endfunction
endpackage

// File: rtl/acq_strobe_gen.sv
module acq_strobe_gen #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [CNT_W-1:0] reload,
  output logic             strobe
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      cnt    <= '0;
      strobe <= 1'b0;
    end else if (cnt >= reload) begin
      cnt    <= '0;
      strobe <= 1'b1;
    end else begin
      cnt    <= cnt + CNT_W'(1);
      strobe <= 1'b0;
    end
  end

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !strobe);

  p_gap_after_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    (strobe && enable && reload != '0) |=> !strobe);
endmodule

// File: rtl/acq_fill_tracker.sv
module acq_fill_tracker #(
  parameter int DEPTH  = 65536,
  parameter int FILL_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [FILL_W-1:0] threshold,
  output logic [FILL_W-1:0] level,
  output logic              irq
);
  localparam logic [FILL_W-1:0] LVL_MAX = FILL_W'(DEPTH);

  logic inc, dec;
  assign inc = wr && (level != LVL_MAX);
  assign dec = rd && (level != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '0;
      irq   <= 1'b0;
    end else begin
      case ({inc, dec})
        2'b10:   level <= level + FILL_W'(1);
        2'b01:   level <= level - FILL_W'(1);
        default: level <= level;
      endcase
      irq <= (level >= threshold);
    end
  end

  p_level_step_r7: assert property (@(posedge clk) disable iff (rst)
    (wr && !rd && level < LVL_MAX) |=> level == $past(level) + FILL_W'(1));

  p_empty_read_r8: assert property (@(posedge clk) disable iff (rst)
    (rd && !wr && level == '0) |=> level == '0);

  p_level_bound_r7: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_MAX);
endmodule

// File: rtl/acq_record_packer.sv
module acq_record_packer
  import acq_pkg::*;
#(
  parameter int ADC_CH    = 3,
  parameter int ADC_W     = 16,
  parameter int POS_CH    = 4,
  parameter int POS_W     = 32,
  parameter int DEPTH     = 65536,
  parameter int FILL_W    = 17,
  parameter int CNT_OUT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     strobe,
  input  logic [ADC_CH*ADC_W-1:0]  adc_flat,
  input  logic [POS_CH*POS_W-1:0]  pos_flat,
  input  logic                     fifo_full,
  input  logic [FILL_W-1:0]        level,
  output logic                     fifo_wr,
  output fifo_word_t               fifo_din,
  output logic [CNT_OUT_W-1:0]     drop_count,
  output logic [CNT_OUT_W-1:0]     overrun_count
);
  localparam int ADC_BITS  = ADC_CH * ADC_W;
  localparam int REC_BITS  = ADC_BITS + POS_CH * POS_W;
  localparam int REC_WORDS = bytes_of(REC_BITS);
  localparam int IDX_W     = $clog2(REC_WORDS);
  localparam logic [IDX_W-1:0]     LAST_IDX = IDX_W'(REC_WORDS - 1);
  localparam logic [FILL_W:0]      ROOM_MAX = (FILL_W+1)'(DEPTH - REC_WORDS);
  localparam logic [CNT_OUT_W-1:0] CMAX     = '1;

  logic [REC_BITS-1:0] rec_bits;

  for (genvar k = 0; k < ADC_CH; k++) begin : g_adc_slot
    assign rec_bits[REC_BITS-1-k*ADC_W -: ADC_W] = adc_flat[k*ADC_W +: ADC_W];
  end
  for (genvar k = 0; k < POS_CH; k++) begin : g_pos_slot
    assign rec_bits[REC_BITS-1-ADC_BITS-k*POS_W -: POS_W] = pos_flat[k*POS_W +: POS_W];
  end

  logic [BYTE_W-1:0] rec_q [REC_WORDS];
  logic              busy;
  logic [IDX_W-1:0]  idx;
  logic [FILL_W:0]   occupied;
  logic              no_room, accept;

  assign occupied = {1'b0, level} + (FILL_W+1)'(fifo_wr);
  assign no_room  = fifo_full || (occupied > ROOM_MAX);
  assign accept   = strobe && !busy && !no_room;

  always_ff @(posedge clk) begin
    if (accept) begin
      for (int b = 0; b < REC_WORDS; b++) begin
        rec_q[b] <= rec_bits[REC_BITS-1-BYTE_W*b -: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy          <= 1'b0;
      idx           <= '0;
      fifo_wr       <= 1'b0;
      fifo_din      <= '0;
      drop_count    <= '0;
      overrun_count <= '0;
    end else begin
      if (busy) begin
        fifo_wr  <= 1'b1;
        fifo_din <= {(idx == '0), rec_q[idx]};
        if (idx == LAST_IDX) begin
          busy <= 1'b0;
          idx  <= '0;
        end else begin
          idx <= idx + IDX_W'(1);
        end
      end else begin
        fifo_wr <= 1'b0;
      end

      if (strobe) begin
        if (busy) begin
          if (overrun_count != CMAX) overrun_count <= overrun_count + CNT_OUT_W'(1);
        end else if (no_room) begin
          if (drop_count != CMAX) drop_count <= drop_count + CNT_OUT_W'(1);
        end else begin
          busy <= 1'b1;
          idx  <= '0;
        end
      end
    end
  end

  p_start_mark_r3: assert property (@(posedge clk) disable iff (rst)
    (fifo_wr && !$past(fifo_wr)) |-> fifo_din[BYTE_W]);

  p_overrun_count_r4: assert property (@(posedge clk) disable iff (rst)
    (strobe && busy && overrun_count != CMAX)
      |=> overrun_count == $past(overrun_count) + CNT_OUT_W'(1));

  p_full_refused_r5: assert property (@(posedge clk) disable iff (rst)
    (strobe && !busy && fifo_full) |=> !busy);

  p_count_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (drop_count == CMAX) |=> drop_count == CMAX);
endmodule

// File: rtl/acq_sync_latch.sv
module acq_sync_latch
  import acq_pkg::*;
#(
  parameter int ADC_CH    = 3,
  parameter int ADC_W     = 16,
  parameter int POS_CH    = 4,
  parameter int POS_W     = 32,
  parameter int CNT_W     = 20,
  parameter int DEPTH     = 65536,
  parameter int CNT_OUT_W = 16,
  localparam int FILL_W   = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    enable,
  input  logic [CNT_W-1:0]        reload,
  input  logic [FILL_W-1:0]       threshold,
  input  logic [ADC_CH*ADC_W-1:0] adc_flat,
  input  logic [POS_CH*POS_W-1:0] pos_flat,
  input  logic                    fifo_full,
  input  logic                    fifo_rd,
  output logic                    sample_strobe,
  output logic                    fifo_wr,
  output logic [8:0]              fifo_din,
  output logic [FILL_W-1:0]       fill_level,
  output logic                    irq,
  output logic [CNT_OUT_W-1:0]    drop_count,
  output logic [CNT_OUT_W-1:0]    overrun_count
);
  fifo_word_t din_w;
  assign fifo_din = din_w;

  acq_strobe_gen #(.CNT_W(CNT_W)) u_strobe (
    .clk    (clk),
    .rst    (rst),
    .enable (enable),
    .reload (reload),
    .strobe (sample_strobe)
  );

  acq_record_packer #(
    .ADC_CH(ADC_CH), .ADC_W(ADC_W), .POS_CH(POS_CH), .POS_W(POS_W),
    .DEPTH(DEPTH), .FILL_W(FILL_W), .CNT_OUT_W(CNT_OUT_W)
  ) u_packer (
    .clk           (clk),
    .rst           (rst),
    .strobe        (sample_strobe),
    .adc_flat      (adc_flat),
    .pos_flat      (pos_flat),
    .fifo_full     (fifo_full),
    .level         (fill_level),
    .fifo_wr       (fifo_wr),
    .fifo_din      (din_w),
    .drop_count    (drop_count),
    .overrun_count (overrun_count)
  );

  acq_fill_tracker #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_fill (
    .clk       (clk),
    .rst       (rst),
    .wr        (fifo_wr),
    .rd        (fifo_rd),
    .threshold (threshold),
    .level     (fill_level),
    .irq       (irq)
  );
endmodule

// File: tb/acq_sync_latch_bench.sv
module acq_sync_latch_bench;
  localparam int DEPTH = 64;
  localparam int FW    = $clog2(DEPTH + 1);
  localparam int CW    = 4;
  localparam int RECW  = 22;
  localparam int CMAXI = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic [19:0] reload = 20'd29;
  logic [FW-1:0] threshold = FW'(30);
  logic [47:0]  adc_flat = '0;
  logic [127:0] pos_flat = '0;
  logic fifo_full = 1'b0;
  logic fifo_rd = 1'b0;
  logic sample_strobe, fifo_wr, irq;
  logic [8:0] fifo_din;
  logic [FW-1:0] fill_level;
  logic [CW-1:0] drop_count, overrun_count;

  always #5 clk = ~clk;

  acq_sync_latch #(.DEPTH(DEPTH), .CNT_OUT_W(CW)) u_acq_sync_latch (
    .clk(clk), .rst(rst), .enable(enable), .reload(reload), .threshold(threshold),
    .adc_flat(adc_flat), .pos_flat(pos_flat), .fifo_full(fifo_full), .fifo_rd(fifo_rd),
    .sample_strobe(sample_strobe), .fifo_wr(fifo_wr), .fifo_din(fifo_din),
    .fill_level(fill_level), .irq(irq), .drop_count(drop_count),
    .overrun_count(overrun_count)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pat = 0;

  // input pattern changes every cycle so the capture edge matters (R2)
  always @(negedge clk) begin
    pat <= pat + 1;
    for (int c = 0; c < 3; c++) adc_flat[c*16 +: 16] <= 16'(pat * 37 + c * 4099);
    for (int c = 0; c < 4; c++) pos_flat[c*32 +: 32] <= 32'(pat * 100003 + c * 16777259);
  end

  // reference model
  int m_cnt, m_strobe, m_busy, m_idx, m_wr, m_din, m_level, m_irq, m_drop, m_ovr;
  int m_rec [RECW];
  int n_cnt, n_strobe, n_busy, n_idx, n_wr, n_din, n_level, n_irq, n_drop, n_ovr;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_strobe = 0; m_busy = 0; m_idx = 0; m_wr = 0; m_din = 0;
      m_level = 0; m_irq = 0; m_drop = 0; m_ovr = 0;
    end else begin
      n_cnt = m_cnt; n_strobe = 0; n_busy = m_busy; n_idx = m_idx; n_wr = 0;
      n_din = m_din; n_drop = m_drop; n_ovr = m_ovr;
      if (!enable) n_cnt = 0;
      else if (m_cnt >= int'(reload)) begin n_cnt = 0; n_strobe = 1; end
      else n_cnt = m_cnt + 1;
      if (m_busy != 0) begin
        n_wr = 1;
        n_din = ((m_idx == 0) ? 256 : 0) + m_rec[m_idx];
        if (m_idx == RECW - 1) begin n_busy = 0; n_idx = 0; end
        else n_idx = m_idx + 1;
      end
      if (m_strobe != 0) begin
        if (m_busy != 0) begin
          if (m_ovr < CMAXI) n_ovr = m_ovr + 1;
        end else if (fifo_full || (DEPTH - (m_level + m_wr) < RECW)) begin
          if (m_drop < CMAXI) n_drop = m_drop + 1;
        end else begin
          int k;
          k = 0;
          for (int c = 0; c < 3; c++) begin
            m_rec[k] = int'(adc_flat[c*16+8 +: 8]); k++;
            m_rec[k] = int'(adc_flat[c*16 +: 8]);   k++;
          end
          for (int c = 0; c < 4; c++) begin
            for (int b = 3; b >= 0; b--) begin
              m_rec[k] = int'(pos_flat[c*32+8*b +: 8]); k++;
            end
          end
          n_busy = 1; n_idx = 0;
        end
      end
      n_level = m_level;
      if (m_wr != 0 && m_level < DEPTH) n_level = n_level + 1;
      if (fifo_rd && m_level > 0) n_level = n_level - 1;
      n_irq = (m_level >= int'(threshold)) ? 1 : 0;
      m_cnt = n_cnt; m_strobe = n_strobe; m_busy = n_busy; m_idx = n_idx;
      m_wr = n_wr; m_din = n_din; m_level = n_level; m_irq = n_irq;
      m_drop = n_drop; m_ovr = n_ovr;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %0d exp %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(int'(sample_strobe) == m_strobe, "R1 strobe", int'(sample_strobe), m_strobe);
      chk(int'(fifo_wr) == m_wr, "R3 fifo_wr", int'(fifo_wr), m_wr);
      if (m_wr != 0) chk(int'(fifo_din) == m_din, "R2 fifo_din", int'(fifo_din), m_din);
      chk(int'(fill_level) == m_level, "R7 fill_level", int'(fill_level), m_level);
      chk(int'(irq) == m_irq, "R9 irq", int'(irq), m_irq);
      chk(int'(drop_count) == m_drop, "R5 drop_count", int'(drop_count), m_drop);
      chk(int'(overrun_count) == m_ovr, "R4 overrun_count", int'(overrun_count), m_ovr);
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog act %0d exp %0d", cyc, 20000);
      finish_run();
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_cyc(4);
    // R11 reset state
    chk(fifo_wr == 1'b0 && irq == 1'b0 && sample_strobe == 1'b0, "R11 reset outputs",
        int'({fifo_wr, irq, sample_strobe}), 0);
    chk(fill_level == '0 && drop_count == '0 && overrun_count == '0, "R11 reset counts",
        int'(fill_level), 0);
    rst = 1'b0;
    wait_cyc(10);
    chk(sample_strobe == 1'b0 && fifo_wr == 1'b0, "R11 disabled quiet", int'(fifo_wr), 0);

    // phase 1: two records fit, third refused for lack of room (R6)
    enable = 1'b1;
    wait_cyc(100);
    chk(fill_level == FW'(44), "R7 level after two records", int'(fill_level), 44);
    chk(drop_count == CW'(1), "R6 space refusal", int'(drop_count), 1);
    chk(irq == 1'b1, "R9 irq at threshold", int'(irq), 1);

    // phase 2: stop, drain past empty (R8)
    enable = 1'b0;
    fifo_rd = 1'b1;
    wait_cyc(60);
    chk(fill_level == '0, "R8 empty reads ignored", int'(fill_level), 0);
    chk(irq == 1'b0, "R9 irq clears below threshold", int'(irq), 0);
    fifo_rd = 1'b0;

    // phase 3: full flag refuses records (R5)
    fifo_full = 1'b1;
    enable = 1'b1;
    wait_cyc(70);
    chk(drop_count == CW'(3), "R5 full refusal", int'(drop_count), 3);
    chk(fill_level == '0, "R5 no write when full", int'(fill_level), 0);
    enable = 1'b0;
    fifo_full = 1'b0;
    wait_cyc(2);

    // phase 4: fast pulses with concurrent reads, overruns saturate (R4, R10)
    reload = 20'd5;
    threshold = FW'(10);
    fifo_rd = 1'b1;
    enable = 1'b1;
    wait_cyc(250);
    chk(overrun_count == CW'(CMAXI), "R10 overrun saturation", int'(overrun_count), CMAXI);
    // lowering reload below the current count forces a pulse next cycle (R1)
    reload = 20'd40;
    wait_cyc(20);
    reload = 20'd3;
    wait_cyc(30);
    enable = 1'b0;
    wait_cyc(40);
    chk(fill_level == '0, "R7 drained after concurrent traffic", int'(fill_level), 0);
    finish_run();
  end
endmodule